// File: doc/BRIEF.md
# Vectored nested priority interrupt controller

This block gathers 32 interrupt source lines and presents one interrupt request line to a processor. It is programmed over a simple word-addressed register bus with separate read and write strobes. For each source, software sets a priority and a trigger type (high or low level, rising or falling edge), and stores a 32-bit vector word. The block selects the enabled pending source with the highest priority. Ties go to the lower source number.

The processor accepts an interrupt by reading the vector-fetch register. That read returns the winner's vector word and clears the winner's latched edge. It also pushes the winner's priority and number onto an 8-level nesting stack. While a handler runs, only a strictly higher priority can raise the request line again. A write to the end-of-interrupt register pops one level. When nothing is eligible, the vector fetch returns a software-programmed spurious word and leaves the stack unchanged.

Top module: `irqn_ctrl`

## Requirements
- R1: After reset the request line is low. The mask, pending, current-source, spurious, mode and vector reads all return 0, with every input held inactive for a low-level trigger (high).
- R2: The mode register of source n is at byte 4*n. Bits [2:0] hold the priority (7 is highest) and bits [5:4] hold the trigger type: 00 low level, 01 falling edge, 10 high level, 11 rising edge. All other bits read 0.
- R3: A write to 0x120 sets every mask bit (readable at 0x110) where the write data has a 1. A write to 0x124 clears every mask bit where the write data has a 1. Bits written 0 are left unchanged.
- R4: The pending word at 0x10C combines two things: a latch per source, and the live level state of each level source. The latch is set by a matching edge or by a 1 written to 0x12C, and cleared by a 1 written to 0x128.
- R5: The winner is the enabled pending source with the highest priority. Among equal priorities, the lowest source number wins.
- R6: The request line is high only when a winner exists and either the stack is empty or the winner's priority is strictly above the top entry's priority.
- R7: A read of 0x100 with an eligible winner does four things: returns the winner's vector word, pushes the winner, clears the winner's latch, and makes 0x108 report the winner's number (0x108 reads 0 when the stack is empty).
- R8: A read of 0x100 with no eligible winner returns the spurious word, which is written and read at 0x134, and does not change the stack.
- R9: A write to 0x130 pops one stack level. With an empty stack it has no effect. Eight pops unwind a full 8-level stack.
- R10: The vector word of source n is written and read at byte 0x80 + 4*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt source lines |
| addr | input | 10 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources, 3-bit priorities and an 8-level stack. Because there are exactly eight priority levels, a chain of strictly rising priorities fills the stack completely. This makes the full-stack, refused-push and full-unwind cases reachable with directed sequences. Randomised masks, priorities and software-set pending words, over all 32 sources, exercise ties and the highest-priority choice against a bench-side model.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_FALL = 2'b01,
    TRG_HIGH = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  localparam int TRG_LSB = 4;

  localparam logic [9:0] A_VEC_FETCH = 10'h100;
  localparam logic [9:0] A_CUR_SRC   = 10'h108;
  localparam logic [9:0] A_PENDING   = 10'h10C;
  localparam logic [9:0] A_MASK      = 10'h110;
  localparam logic [9:0] A_EN_CMD    = 10'h120;
  localparam logic [9:0] A_DIS_CMD   = 10'h124;
  localparam logic [9:0] A_CLR_PEND  = 10'h128;
  localparam logic [9:0] A_SET_PEND  = 10'h12C;
  localparam logic [9:0] A_EOI       = 10'h130;
  localparam logic [9:0] A_SPUR      = 10'h134;
endpackage

// File: rtl/irqn_src_bank.sv
module irqn_src_bank
  import irqn_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSRC-1:0]           src_in,
  input  logic                      cfg_we,
  input  logic [IDW-1:0]            cfg_idx,
  input  logic [PW-1:0]             cfg_prio,
  input  logic [1:0]                cfg_trig,
  input  logic [NSRC-1:0]           sw_set,
  input  logic [NSRC-1:0]           sw_clr,
  input  logic                      ack,
  input  logic [IDW-1:0]            ack_idx,
  output logic [NSRC-1:0][PW-1:0]   prio_o,
  output logic [NSRC-1:0][1:0]      trig_o,
  output logic [NSRC-1:0]           pend_o
);
  logic [NSRC-1:0]         in_q, in_qq, latch_q;
  logic [NSRC-1:0]         lvl_hit, edge_hit, kill;
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [NSRC-1:0][1:0]    trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '0;
      in_qq  <= '0;
      prio_q <= '0;
      trig_q <= '0;
    end else begin
      in_q  <= src_in;
      in_qq <= in_q;
      if (cfg_we) begin
        prio_q[cfg_idx] <= cfg_prio;
        trig_q[cfg_idx] <= cfg_trig;
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    trig_e t;
    assign t           = trig_e'(trig_q[i]);
    assign lvl_hit[i]  = ((t == TRG_LOW) && !in_q[i]) || ((t == TRG_HIGH) && in_q[i]);
    assign edge_hit[i] = ((t == TRG_RISE) && in_q[i] && !in_qq[i]) ||
                         ((t == TRG_FALL) && !in_q[i] && in_qq[i]);
    assign kill[i]     = sw_clr[i] || (ack && (ack_idx == IDW'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= (latch_q & ~kill) | edge_hit | sw_set;
  end

  assign pend_o = latch_q | lvl_hit;
  assign prio_o = prio_q;
  assign trig_o = trig_q;

  // R4: a software set is visible as pending on the next cycle
  a_r4_sw_set_latches: assert property (@(posedge clk) disable iff (rst)
    (|sw_set) |=> ((pend_o & $past(sw_set)) == $past(sw_set)));
endmodule

// File: rtl/irqn_arbiter.sv
module irqn_arbiter #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input  logic [NSRC-1:0]         cand,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic                    win_valid,
  output logic [IDW-1:0]          win_id,
  output logic [PW-1:0]           win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!win_valid || (prio[i] > win_prio))) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqn_nest_stack.sv
module irqn_nest_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int IDW   = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [PW-1:0]  push_prio,
  input  logic [IDW-1:0] push_id,
  input  logic           pop,
  output logic           empty,
  output logic [PW-1:0]  top_prio,
  output logic [IDW-1:0] top_id
);
  logic [PW-1:0]  prio_m [DEPTH];
  logic [IDW-1:0] id_m   [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_after_pop;
  logic           push_ok;

  assign empty         = (cnt_q == '0);
  assign cnt_after_pop = (pop && !empty) ? cnt_q - 1'b1 : cnt_q;
  assign push_ok       = push && (cnt_after_pop < CW'(DEPTH));
  assign top_prio      = empty ? '0 : prio_m[cnt_q - 1'b1];
  assign top_id        = empty ? '0 : id_m[cnt_q - 1'b1];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      prio_m[cnt_after_pop] <= push_prio;
      id_m[cnt_after_pop]   <= push_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_after_pop + CW'(push_ok);
  end

  // R9: occupancy never exceeds the depth
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R6: a nested entry always outranks the one beneath it
  a_r6_nest_rises: assert property (@(posedge clk) disable iff (rst)
    (push && !empty && !pop) |-> (push_prio > top_prio));
  // R9: a push arriving at a full stack is never requested
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt_q < CW'(DEPTH)));
endmodule

// File: rtl/irqn_vec_store.sv
module irqn_vec_store #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int IDW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [IDW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [IDW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0]   mem [NSRC];
  logic [NSRC-1:0] written_q;
  logic [DW-1:0]   mem_q;
  logic            ok_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      ok_q      <= 1'b0;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      if (re) ok_q <= written_q[raddr];
    end
  end

  assign rdata = ok_q ? mem_q : '0;
endmodule

// File: rtl/irqn_ctrl.sv
module irqn_ctrl
  import irqn_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int PW    = 3,
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 10,
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  input  logic            rd_en,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  logic                    word_ok, in_mode, in_vec;
  logic [IDW-1:0]          idx;
  logic [NSRC-1:0][PW-1:0] prio;
  logic [NSRC-1:0][1:0]    trig;
  logic [NSRC-1:0]         pend, sw_set, sw_clr, mask_q;
  logic                    win_valid, beats, accept, pop;
  logic [IDW-1:0]          win_id, top_id, vec_raddr;
  logic [PW-1:0]           win_prio, top_prio;
  logic                    stk_empty;
  logic [DW-1:0]           spur_q, misc_q, misc_d, vec_rd;
  logic                    sel_vec_q, irq_q;

  assign word_ok = (addr[1:0] == 2'b00);
  assign in_mode = word_ok && (addr[AW-1:7] == '0);
  assign in_vec  = word_ok && (addr[AW-1:7] == (AW-7)'(1));
  assign idx     = addr[IDW+1:2];

  assign sw_set = (wr_en && addr == A_SET_PEND) ? wdata[NSRC-1:0] : '0;
  assign sw_clr = (wr_en && addr == A_CLR_PEND) ? wdata[NSRC-1:0] : '0;
  assign beats  = stk_empty || (win_prio > top_prio);
  assign accept = rd_en && (addr == A_VEC_FETCH) && win_valid && beats;
  assign pop    = wr_en && (addr == A_EOI);
  assign vec_raddr = (addr == A_VEC_FETCH) ? win_id : idx;

  irqn_src_bank #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_bank (
    .clk(clk), .rst(rst), .src_in(src_in),
    .cfg_we(wr_en && in_mode), .cfg_idx(idx),
    .cfg_prio(wdata[PW-1:0]), .cfg_trig(wdata[TRG_LSB+:2]),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .ack(accept), .ack_idx(win_id),
    .prio_o(prio), .trig_o(trig), .pend_o(pend)
  );

  irqn_arbiter #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
    .cand(pend & mask_q), .prio(prio),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  irqn_nest_stack #(.DEPTH(DEPTH), .PW(PW), .IDW(IDW)) u_stack (
    .clk(clk), .rst(rst),
    .push(accept), .push_prio(win_prio), .push_id(win_id),
    .pop(pop), .empty(stk_empty), .top_prio(top_prio), .top_id(top_id)
  );

  irqn_vec_store #(.NSRC(NSRC), .DW(DW), .IDW(IDW)) u_vec (
    .clk(clk), .rst(rst),
    .we(wr_en && in_vec), .waddr(idx), .wdata(wdata),
    .re(rd_en), .raddr(vec_raddr), .rdata(vec_rd)
  );

  always_comb begin
    misc_d = '0;
    if (in_mode) begin
      misc_d[PW-1:0]       = prio[idx];
      misc_d[TRG_LSB+:2]   = trig[idx];
    end else begin
      case (addr)
        A_VEC_FETCH, A_SPUR: misc_d = spur_q;
        A_CUR_SRC:           misc_d = DW'(top_id);
        A_PENDING:           misc_d = DW'(pend);
        A_MASK:              misc_d = DW'(mask_q);
        default:             misc_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      spur_q    <= '0;
      misc_q    <= '0;
      sel_vec_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= win_valid && beats;
      if (wr_en && addr == A_EN_CMD)  mask_q <= mask_q | wdata[NSRC-1:0];
      if (wr_en && addr == A_DIS_CMD) mask_q <= mask_q & ~wdata[NSRC-1:0];
      if (wr_en && addr == A_SPUR)    spur_q <= wdata;
      if (rd_en) begin
        misc_q    <= misc_d;
        sel_vec_q <= in_vec || accept;
      end
    end
  end

  assign rdata = sel_vec_q ? vec_rd : misc_q;
  assign irq   = irq_q;

  // R3: enable command sets every requested mask bit
  a_r3_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_EN_CMD) |=> ((mask_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
  // R3: disable command clears every requested mask bit
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIS_CMD) |=> ((mask_q & $past(wdata[NSRC-1:0])) == '0));
  // R6: request only follows a cycle with an eligible winner
  a_r6_irq_needs_winner: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(win_valid));
  // R8: a refused vector fetch returns the spurious word
  a_r8_spurious_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_VEC_FETCH && !accept) |=> (rdata == $past(spur_q)));
endmodule

// File: tb/irqn_ctrl_tb_top.sv
`timescale 1ns/1ps
module irqn_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '1;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;
  int          prio_m [32];

  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  always #2 clk = ~clk;

  irqn_ctrl dut_i (.clk(clk), .rst(rst), .src_in(src_in), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] vexp(int i);
    return 32'h0000_1000 + 32'(i) * 32'h10;
  endfunction

  function automatic int pick(logic [31:0] cand);
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (cand[i] && (best < 0 || prio_m[i] > prio_m[best])) best = i;
    return best;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int s, int p, logic [1:0] t);
    prio_m[s] = p;
    wr(10'(4 * s), {26'd0, t, 1'b0, 3'(p)});
  endtask

  task automatic wipe();
    wr(10'h124, '1);
    wr(10'h128, '1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] msk, sp;
    int w;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(2);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(10'h110, d); check("R1 mask", d, 0);
    rd(10'h10C, d); check("R1 pending", d, 0);
    rd(10'h108, d); check("R1 current", d, 0);
    rd(10'h134, d); check("R1 spurious", d, 0);
    rd(10'h014, d); check("R1 mode", d, 0);
    rd(10'h084, d); check("R1 vector", d, 0);
    rd(10'h100, d); check("R1 fetch", d, 0);

    wr(10'h134, SPUR);
    for (int i = 0; i < 32; i++) wr(10'(10'h80 + 4 * i), vexp(i));
    for (int i = 0; i < 32; i++) set_mode(i, 0, 2'b11);
    // R10 vector words
    rd(10'h094, d); check("R10 vector 5", d, vexp(5));
    rd(10'h0FC, d); check("R10 vector 31", d, vexp(31));
    // R2 mode field layout
    wr(10'h01C, 32'hFFFF_FFFF);
    rd(10'h01C, d); check("R2 mode fields", d, 32'h37);
    set_mode(7, 0, 2'b11);
    rd(10'h01C, d); check("R2 mode rewrite", d, 32'h30);
    // R3 mask commands
    wr(10'h120, 32'hF0); rd(10'h110, d); check("R3 enable", d, 32'hF0);
    wr(10'h120, 32'h03); rd(10'h110, d); check("R3 enable keeps", d, 32'hF3);
    wr(10'h124, 32'h30); rd(10'h110, d); check("R3 disable", d, 32'hC3);
    wr(10'h124, '1);     rd(10'h110, d); check("R3 disable all", d, 0);
    // R4 pending sources
    wr(10'h12C, 32'h101); rd(10'h10C, d); check("R4 sw set", d, 32'h101);
    wr(10'h128, 32'h001); rd(10'h10C, d); check("R4 sw clear", d, 32'h100);
    wr(10'h128, '1);
    set_mode(3, 0, 2'b01);
    src_in[3] = 1'b0; settle(4);
    rd(10'h10C, d); check("R4 falling edge", d, 32'h8);
    src_in[3] = 1'b1; settle(4);
    rd(10'h10C, d); check("R4 edge latched", d, 32'h8);
    wr(10'h128, 32'h8); rd(10'h10C, d); check("R4 edge cleared", d, 0);
    set_mode(3, 0, 2'b11);
    set_mode(4, 0, 2'b10); settle(2);
    rd(10'h10C, d); check("R4 high level", d, 32'h10);
    src_in[4] = 1'b0; settle(4);
    rd(10'h10C, d); check("R4 level released", d, 0);
    src_in[4] = 1'b1; set_mode(4, 0, 2'b11); settle(4);
    rd(10'h10C, d); check("R4 no edge on mode", d, 0);
    src_in[6] = 1'b0; settle(4); src_in[6] = 1'b1; settle(4);
    rd(10'h10C, d); check("R4 rising edge", d, 32'h40);
    wipe();
    // R6 R7 R8 R9 nesting
    set_mode(9, 2, 2'b11); set_mode(10, 2, 2'b11); set_mode(11, 5, 2'b11);
    wr(10'h120, 32'h0E00);
    wr(10'h12C, 32'h0200); settle(3);
    check("R6 irq empty stack", 32'(irq), 1);
    rd(10'h100, d); check("R7 fetch 9", d, vexp(9));
    settle(3);
    check("R6 irq after accept", 32'(irq), 0);
    rd(10'h108, d); check("R7 current 9", d, 9);
    rd(10'h10C, d); check("R7 latch cleared", d, 0);
    wr(10'h12C, 32'h0400); settle(3);
    check("R6 equal prio blocked", 32'(irq), 0);
    rd(10'h100, d); check("R8 spurious equal", d, SPUR);
    rd(10'h108, d); check("R8 stack unchanged", d, 9);
    wr(10'h12C, 32'h0800); settle(3);
    check("R6 higher prio", 32'(irq), 1);
    rd(10'h100, d); check("R7 fetch 11", d, vexp(11));
    rd(10'h108, d); check("R7 current 11", d, 11);
    wr(10'h130, 0); rd(10'h108, d); check("R9 pop to 9", d, 9);
    settle(2); check("R6 still blocked", 32'(irq), 0);
    wr(10'h130, 0); rd(10'h108, d); check("R9 pop to empty", d, 0);
    settle(2); check("R6 irq after unwind", 32'(irq), 1);
    rd(10'h100, d); check("R7 fetch 10", d, vexp(10));
    wr(10'h130, 0); wr(10'h130, 0);
    rd(10'h108, d); check("R9 pop on empty", d, 0);
    rd(10'h100, d); check("R8 spurious idle", d, SPUR);
    wipe();
    // R5 tie
    set_mode(12, 4, 2'b11); set_mode(20, 4, 2'b11);
    wr(10'h120, 32'h0010_1000); wr(10'h12C, 32'h0010_1000);
    rd(10'h100, d); check("R5 tie lowest", d, vexp(12));
    wr(10'h130, 0); wipe();
    // R9 full stack
    for (int p = 0; p < 8; p++) set_mode(24 + p, p, 2'b11);
    set_mode(23, 7, 2'b11);
    wr(10'h120, 32'hFF80_0000);
    for (int p = 0; p < 8; p++) begin
      wr(10'h12C, 32'(1) << (24 + p));
      rd(10'h100, d); check("R9 fill", d, vexp(24 + p));
    end
    rd(10'h108, d); check("R9 full top", d, 31);
    wr(10'h12C, 32'h0080_0000); settle(3);
    check("R9 full blocks irq", 32'(irq), 0);
    rd(10'h100, d); check("R9 full refuses", d, SPUR);
    for (int k = 0; k < 7; k++) wr(10'h130, 0);
    rd(10'h108, d); check("R9 seven pops", d, 24);
    wr(10'h130, 0);
    rd(10'h108, d); check("R9 eight pops", d, 0);
    settle(2); check("R9 irq free", 32'(irq), 1);
    rd(10'h100, d); check("R9 fetch 23", d, vexp(23));
    wr(10'h130, 0); wipe();
    // R5 R6 R7 random
    for (int it = 0; it < 16; it++) begin
      for (int i = 0; i < 32; i++) set_mode(i, int'($urandom_range(7)), 2'b11);
      msk = $urandom; sp = $urandom;
      if (it == 0) sp = 0;
      wr(10'h120, msk); wr(10'h12C, sp); settle(3);
      w = pick(msk & sp);
      check("R6 random irq", 32'(irq), (w >= 0) ? 1 : 0);
      rd(10'h100, d);
      check("R5 random winner", d, (w >= 0) ? vexp(w) : SPUR);
      if (w >= 0) begin
        rd(10'h108, d); check("R7 random current", d, 32'(w));
        wr(10'h130, 0);
      end
      wipe();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule